// File: doc/BRIEF.md
# Audio Subframe Sample Formatter

This block sits between a serial digital-audio line decoder and a capture buffer. Each decoded 32-bit subframe arrives with a valid strobe. A tag marks it as belonging to the primary or the secondary channel, and a two-bit code reports which preamble opened it. The block decides whether the subframe is kept, reshapes it into one 32-bit capture word, and presents that word with a valid strobe one cycle later.

Two settings govern the block. The channel setting keeps both channels as left/right pairs, or only the primary, or only the secondary. The sample setting packs a 16-bit sample, or packs a 24-bit sample through an 8-bit mask with zero padding, or keeps the whole subframe with its low nibble replaced by a preamble code. Both settings are taken from their inputs only while capture is off. They hold for as long as capture stays on, so software may rewrite them at any time without corrupting a running capture.

Top module: `sfx_subframe_fmt`

## Requirements
- R1: In 16-bit packing (sample setting 0), a kept subframe d yields out_word = {16'h0000, d[27:12]}.
- R2: In masked packing (sample setting 1), a kept subframe d yields out_word = {d[27:12], d[11:4] & smask, 8'h00}, where smask is the mask input sampled in the same cycle as the subframe.
- R3: The mask input has no effect on out_word in 16-bit packing or in raw capture.
- R4: In raw capture (sample setting 2), a kept subframe d yields out_word = {d[31:4], code}. The code is 4'h1 for preamble input 0 (block start), 4'h2 for input 1 (primary), 4'h3 for input 2 (secondary) and 4'h0 for input 3.
- R5: Channel setting 0 keeps subframes of both channels. Setting 1 keeps only those with sf_is_sec = 0. Setting 2 keeps only those with sf_is_sec = 1.
- R6: With channel setting 0, a secondary subframe is dropped if no primary subframe has been kept since capture was last enabled, so captured data always begins with a left sample.
- R7: The reserved encodings (channel setting 3 or sample setting 3) produce no output words.
- R8: The settings are copied from their inputs on every cycle that cap_en is low. Changes while cap_en is high are ignored until capture is next turned off.
- R9: No output word is produced for subframes presented while cap_en is low.
- R10: out_valid pulses for exactly one cycle, in the cycle after a kept subframe's sf_valid, and is otherwise low. After reset, out_valid and out_word are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Capture enable; settings are copied while low |
| chan_mode_in | input | 2 | Channel setting: 0 pairs, 1 primary, 2 secondary, 3 reserved |
| samp_mode_in | input | 2 | Sample setting: 0 16-bit, 1 masked, 2 raw, 3 reserved |
| smask | input | 8 | Mask on subframe bits [11:4] in masked packing |
| sf_valid | input | 1 | Subframe strobe, one cycle per subframe |
| sf_data | input | 32 | Decoded subframe bits |
| sf_is_sec | input | 1 | 1 = secondary channel subframe |
| sf_pre | input | 2 | Preamble: 0 block start, 1 primary, 2 secondary, 3 other |
| out_valid | output | 1 | Capture word strobe |
| out_word | output | 32 | Formatted capture word |

## Verification
A corrupted settings register shows up in the next output word as a wrong bit layout or a word from the wrong channel. That happens within one cycle of the next subframe. A left-pair flag stuck high lets a lone secondary subframe through right after enable, and a flag stuck low silences every right sample. The scoreboard catches both on the first word that is missing or extra. A bad mask or code path changes bits [11:0] of the very word concerned.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

    localparam int SF_W     = 32;
    localparam int MASK_W   = 8;
    localparam int CODE_W   = 4;
    localparam int HI_TOP   = 27;
    localparam int HI_W     = 16;
    localparam int HI_LO    = HI_TOP - HI_W + 1;      // 12
    localparam int MID_LO   = HI_LO - MASK_W;         // 4
    localparam int PAD_W    = SF_W - HI_W - MASK_W;   // 8

    typedef enum logic [1:0] {
        CH_PAIR = 2'd0,
        CH_PRI  = 2'd1,
        CH_SEC  = 2'd2,
        CH_RSVD = 2'd3
    } chan_sel_e;

    typedef enum logic [1:0] {
        PK_16   = 2'd0,
        PK_MASK = 2'd1,
        PK_RAW  = 2'd2,
        PK_RSVD = 2'd3
    } pack_sel_e;

    typedef enum logic [1:0] {
        PRE_BLOCK = 2'd0,
        PRE_PRI   = 2'd1,
        PRE_SEC   = 2'd2,
        PRE_OTHER = 2'd3
    } pre_kind_e;

    typedef struct packed {
        chan_sel_e chan;
        pack_sel_e pack;
    } fmt_cfg_t;

    typedef struct packed {
        logic [SF_W-1:0] bits;
        logic            is_sec;
        pre_kind_e       pre;
    } subframe_t;

    localparam fmt_cfg_t CFG_RESET = '{chan: CH_PAIR, pack: PK_16};

    function automatic logic [CODE_W-1:0] pre_code(input pre_kind_e p);
        case (p)
            PRE_BLOCK: return 4'h1;
            PRE_PRI:   return 4'h2;
            PRE_SEC:   return 4'h3;
            default:   return 4'h0;
        endcase
    endfunction

    function automatic logic [SF_W-1:0] pack_word(
        input pack_sel_e         mode,
        input subframe_t         sf,
        input logic [MASK_W-1:0] mask
    );
        logic [SF_W-1:0] w;
        w = '0;
        case (mode)
            PK_16:   w = {{(SF_W-HI_W){1'b0}}, sf.bits[HI_TOP:HI_LO]};
            PK_MASK: w = {sf.bits[HI_TOP:HI_LO],
                          sf.bits[HI_LO-1:MID_LO] & mask,
                          {PAD_W{1'b0}}};
            PK_RAW:  w = {sf.bits[SF_W-1:CODE_W], pre_code(sf.pre)};
            default: w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/sfx_cfg_hold.sv
module sfx_cfg_hold
    import sfx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cap_en,
    input  logic [1:0] chan_in,
    input  logic [1:0] pack_in,
    output fmt_cfg_t cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (!cap_en) begin
            cfg <= '{chan: chan_sel_e'(chan_in), pack: pack_sel_e'(pack_in)};
        end
    end

    // R8: settings frozen while capture stays enabled
    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cap_en)) |-> $stable(cfg));

endmodule

// File: rtl/sfx_chan_gate.sv
module sfx_chan_gate
    import sfx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cap_en,
    input  fmt_cfg_t cfg,
    input  logic     sf_valid,
    input  logic     sf_is_sec,
    output logic     keep
);

    logic left_seen;
    logic mode_ok;
    logic chan_ok;

    always_comb begin
        mode_ok = (cfg.chan != CH_RSVD) && (cfg.pack != PK_RSVD);
        case (cfg.chan)
            CH_PAIR: chan_ok = !sf_is_sec || left_seen;
            CH_PRI:  chan_ok = !sf_is_sec;
            CH_SEC:  chan_ok = sf_is_sec;
            default: chan_ok = 1'b0;
        endcase
        keep = sf_valid && cap_en && mode_ok && chan_ok;
    end

    always_ff @(posedge clk) begin
        if (rst || !cap_en) begin
            left_seen <= 1'b0;
        end else if (keep && !sf_is_sec) begin
            left_seen <= 1'b1;
        end
    end

    // R6: the pair flag can only be set while capture is running
    p_left_needs_en_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cap_en)) |-> !left_seen);

endmodule

// File: rtl/sfx_packer.sv
module sfx_packer
    import sfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              keep,
    input  pack_sel_e         pack,
    input  subframe_t         sf,
    input  logic [MASK_W-1:0] mask,
    output logic              out_valid,
    output logic [SF_W-1:0]   out_word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= keep;
            if (keep) begin
                out_word <= pack_word(pack, sf, mask);
            end
        end
    end

endmodule

// File: rtl/sfx_subframe_fmt.sv
module sfx_subframe_fmt
    import sfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [1:0]        chan_mode_in,
    input  logic [1:0]        samp_mode_in,
    input  logic [MASK_W-1:0] smask,
    input  logic              sf_valid,
    input  logic [SF_W-1:0]   sf_data,
    input  logic              sf_is_sec,
    input  logic [1:0]        sf_pre,
    output logic              out_valid,
    output logic [SF_W-1:0]   out_word
);

    fmt_cfg_t  cfg;
    subframe_t sf;
    logic      keep;

    assign sf = '{bits: sf_data, is_sec: sf_is_sec, pre: pre_kind_e'(sf_pre)};

    sfx_cfg_hold u_cfg (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (cap_en),
        .chan_in (chan_mode_in),
        .pack_in (samp_mode_in),
        .cfg     (cfg)
    );

    sfx_chan_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (cap_en),
        .cfg       (cfg),
        .sf_valid  (sf_valid),
        .sf_is_sec (sf_is_sec),
        .keep      (keep)
    );

    sfx_packer u_pack (
        .clk       (clk),
        .rst       (rst),
        .keep      (keep),
        .pack      (cfg.pack),
        .sf        (sf),
        .mask      (smask),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    // R7: reserved settings never yield a word
    p_rsvd_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(cfg.chan) == CH_RSVD || $past(cfg.pack) == PK_RSVD))
        |-> !out_valid);

    // R9: nothing captured while disabled
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cap_en)) |-> !out_valid);

    // R10: a word follows a strobed subframe only
    p_word_follows_sf_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(sf_valid)) |-> !out_valid);

    // R2: masked packing leaves the low byte zero
    p_pad_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && out_valid && $past(cfg.pack) == PK_MASK)
        |-> (out_word[PAD_W-1:0] == '0));

    // R1: 16-bit packing leaves the upper half zero
    p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && out_valid && $past(cfg.pack) == PK_16)
        |-> (out_word[SF_W-1:HI_W] == '0));

    // R5: primary-only setting never passes a secondary subframe
    p_pri_only_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && out_valid && $past(cfg.chan) == CH_PRI) |-> !$past(sf_is_sec));

endmodule

// File: tb/sfx_subframe_fmt_tb_top.sv
module sfx_subframe_fmt_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cap_en;
    logic [1:0]  chan_mode_in;
    logic [1:0]  samp_mode_in;
    logic [7:0]  smask;
    logic        sf_valid;
    logic [31:0] sf_data;
    logic        sf_is_sec;
    logic [1:0]  sf_pre;
    logic        out_valid;
    logic [31:0] out_word;

    int total = 0;
    int bad   = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    // bench model of the active settings
    logic [1:0] m_ch;
    logic [1:0] m_pk;
    bit         m_left;
    bit         m_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfx_subframe_fmt dut_i (
        .clk          (clk),
        .rst          (rst),
        .cap_en       (cap_en),
        .chan_mode_in (chan_mode_in),
        .samp_mode_in (samp_mode_in),
        .smask        (smask),
        .sf_valid     (sf_valid),
        .sf_data      (sf_data),
        .sf_is_sec    (sf_is_sec),
        .sf_pre       (sf_pre),
        .out_valid    (out_valid),
        .out_word     (out_word)
    );

    function automatic logic [31:0] model_word(logic [1:0] pk, logic [31:0] d,
                                               logic [1:0] p, logic [7:0] m);
        logic [3:0] c;
        c = (p == 2'd0) ? 4'h1 : (p == 2'd1) ? 4'h2 : (p == 2'd2) ? 4'h3 : 4'h0;
        case (pk)
            2'd0:    return {16'h0000, d[27:12]};
            2'd1:    return {d[27:12], d[11:4] & m, 8'h00};
            default: return {d[31:4], c};
        endcase
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R10 unexpected word: actual=%h expected=none", out_word);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (out_word !== e) begin
                    bad++;
                    $display("FAIL %s word: actual=%h expected=%h", t, out_word, e);
                end
            end
        end
    end

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    // program settings while disabled, then enable
    task automatic start(logic [1:0] ch, logic [1:0] pk);
        @(negedge clk);
        cap_en = 1'b0;
        chan_mode_in = ch;
        samp_mode_in = pk;
        m_en = 0;
        m_left = 0;
        settle(2);
        cap_en = 1'b1;
        m_ch = ch;
        m_pk = pk;
        m_en = 1;
    endtask

    task automatic stop();
        @(negedge clk);
        cap_en = 1'b0;
        m_en = 0;
        m_left = 0;
    endtask

    task automatic send(logic [31:0] d, logic sec, logic [1:0] p, logic [7:0] m, string t);
        bit k;
        @(negedge clk);
        sf_valid  = 1'b1;
        sf_data   = d;
        sf_is_sec = sec;
        sf_pre    = p;
        smask     = m;
        k = m_en && m_ch != 2'd3 && m_pk != 2'd3;
        case (m_ch)
            2'd0: k = k && (!sec || m_left);
            2'd1: k = k && !sec;
            2'd2: k = k && sec;
            default: k = 1'b0;
        endcase
        if (k && !sec) m_left = 1;
        if (k) begin
            exp_q.push_back(model_word(m_pk, d, p, m));
            tag_q.push_back(t);
        end
        @(negedge clk);
        sf_valid = 1'b0;
    endtask

    task automatic drain(string t);
        settle(3);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL %s missing words: actual=%0d pending expected=0", t, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R10 watchdog expired: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cap_en = 1'b0; chan_mode_in = 2'd0; samp_mode_in = 2'd0;
        smask = 8'h00; sf_valid = 1'b0; sf_data = '0; sf_is_sec = 1'b0; sf_pre = 2'd0;
        m_ch = 0; m_pk = 0; m_left = 0; m_en = 0;
        settle(3);
        rst = 1'b0;
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || out_word !== 32'h0) begin
            bad++;
            $display("FAIL R10 reset state: actual=%b/%h expected=0/00000000", out_valid, out_word);
        end

        // R1 + R5: 16-bit, primary only
        start(2'd1, 2'd0);
        send(32'hDEAD_BEEF, 1'b0, 2'd1, 8'hFF, "R1");
        send(32'h1234_5678, 1'b1, 2'd2, 8'hFF, "R5");
        send(32'h0FFF_F000, 1'b0, 2'd0, 8'h00, "R1");
        drain("R5 pri-only");

        // R2 + R5: masked packing, secondary only
        start(2'd2, 2'd1);
        send(32'hCAFE_F00D, 1'b1, 2'd2, 8'hFF, "R2");
        send(32'hCAFE_F00D, 1'b1, 2'd2, 8'h0F, "R2");
        send(32'hA5A5_A5A5, 1'b1, 2'd2, 8'h00, "R2");
        send(32'h7777_7777, 1'b0, 2'd1, 8'hFF, "R5");
        drain("R5 sec-only");

        // R3: mask has no effect outside masked packing
        start(2'd1, 2'd0);
        send(32'h0ABC_DEF0, 1'b0, 2'd1, 8'h00, "R3");
        start(2'd1, 2'd2);
        send(32'hFEDC_BA98, 1'b0, 2'd1, 8'h00, "R3");
        drain("R3");

        // R6 + R4: pairs in raw capture, lone right sample first
        start(2'd0, 2'd2);
        send(32'h1111_1111, 1'b1, 2'd2, 8'h00, "R6");
        send(32'h2222_2222, 1'b0, 2'd0, 8'h00, "R4");
        send(32'h3333_3333, 1'b1, 2'd2, 8'h00, "R4");
        send(32'h4444_4444, 1'b0, 2'd1, 8'h00, "R4");
        send(32'h5555_5555, 1'b1, 2'd3, 8'h00, "R4");
        drain("R6 pairs");

        // R7: reserved settings
        start(2'd3, 2'd0);
        send(32'h6666_6666, 1'b0, 2'd1, 8'hFF, "R7");
        send(32'h6666_6666, 1'b1, 2'd2, 8'hFF, "R7");
        start(2'd0, 2'd3);
        send(32'h8888_8888, 1'b0, 2'd1, 8'hFF, "R7");
        drain("R7");

        // R8: writes while enabled are ignored until the next disable
        start(2'd1, 2'd0);
        chan_mode_in = 2'd2;
        samp_mode_in = 2'd2;
        settle(2);
        send(32'h9ABC_DEF1, 1'b0, 2'd1, 8'hFF, "R8");
        send(32'h9ABC_DEF1, 1'b1, 2'd2, 8'hFF, "R8");
        drain("R8 frozen");
        stop();
        settle(1);
        cap_en = 1'b1; m_en = 1; m_ch = 2'd2; m_pk = 2'd2;
        send(32'h0F0F_0F0F, 1'b1, 2'd2, 8'h00, "R8");
        drain("R8 reload");

        // R9: disabled capture produces nothing
        stop();
        send(32'hFFFF_FFFF, 1'b1, 2'd2, 8'hFF, "R9");
        send(32'hFFFF_FFFF, 1'b0, 2'd1, 8'hFF, "R9");
        drain("R9");

        // R6 again: pair flag cleared by disable
        start(2'd0, 2'd0);
        send(32'h1357_9BDF, 1'b0, 2'd1, 8'h00, "R6");
        send(32'h2468_ACE0, 1'b1, 2'd2, 8'h00, "R6");
        stop();
        settle(1);
        cap_en = 1'b1; m_en = 1;
        send(32'hBBBB_BBBB, 1'b1, 2'd2, 8'h00, "R6");
        drain("R6 re-enable");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule